// File: doc/BRIEF.md
# Dual-Channel DAC Digital Front End

This block is the digital control for a pair of 12-bit converter channels. Software or a DMA engine writes sample values into a holding register for each channel. The write can use one of three data layouts. The block decides when each held value moves into the output register that feeds the converter. It can do this on the next cycle, or it can wait for a trigger taken from one of seven external sources or from a software request.

When triggering is enabled, the block can add a hardware waveform to the held value on every transfer. The waveform is either pseudo-random noise from a 12-bit LFSR or a triangle of programmable amplitude. The sum saturates at full scale. In dual mode, channel 0's timing drives both channels, so the two outputs change on the same edge.

Each triggered transfer can raise a DMA request. If a trigger arrives while the previous request is still unserviced, the block raises a sticky underrun flag, and that flag blocks further requests until software clears it.

Top module: `dac_pair_ctrl`

## Requirements
- R1: After reset, both outputs are 0, and no DMA request, underrun flag or software-pending bit is set.
- R2: The write format is set by `wrFmt`:
  - 0: right-aligned 12-bit, taken from lane bits [11:0].
  - 1: left-aligned 12-bit, taken from lane bits [15:4].
  - 2: 8-bit, where lane bits [7:0] become the upper eight bits of the 12-bit value and the lower four bits are zero.
  - Lanes for `wrChan` 0 or 1: the lane is `wrData[15:0]`.
  - Lanes for `wrChan` 2 (both channels): channel 0 uses `wrData[15:0]` and channel 1 uses `wrData[31:16]`. In format 2, channel 0 uses `wrData[7:0]` and channel 1 uses `wrData[15:8]`.
- R3: With triggering disabled for a channel, its output takes the held value at the second clock edge after the write. The edge that loads the holding register leaves the output unchanged. Trigger inputs have no effect on that channel.
- R4: With triggering enabled, the 3-bit select picks the trigger source:
  - Codes 0 to 6 select a rising edge on `extTrig[code]`.
  - Code 7 selects the software request.
  - The output changes only on the clock edge where the selected source fires. Unselected sources leave it unchanged.
- R5: A pulse on `swSet` sets the channel's pending bit at the next edge. When code 7 is selected with triggering on, the following edge performs the transfer and clears the pending bit.
- R6: With `dualMode` set, channel 1 transfers exactly when channel 0 does, using channel 0's trigger settings, and channel 1's own trigger settings have no effect.
- R7: In noise mode (wave code 1), each triggered transfer outputs the held value plus (LFSR AND mask) and then steps the LFSR.
  - LFSR reset value: 0xAAA.
  - Step rule: the next state is {state[10:0], state[11]^state[5]^state[3]^state[0]}.
  - Mask: 2^(amp+1)−1, using the channel's 4-bit `waveAmp`.
- R8: In triangle mode (wave code 2), each triggered transfer outputs the held value plus a counter and then steps the counter.
  - The counter starts at 0 and counts up to 2^(amp+1)−1.
  - It then counts back down to 0 and repeats.
  - The value used is the one before the step.
  - Wave codes 0 and 3 add nothing.
- R9: Whenever the held value plus the wave value exceeds 0xFFF, the output is 0xFFF.
- R10: With DMA enabled, a triggered transfer raises `dmaReq` on the same edge. The request stays high until `dmaAck` is seen at a clock edge.
- R11: Underrun behaviour:
  - A triggered transfer while the request is still high and not being acknowledged sets `underrun` and drops the request.
  - `underrun` stays set until `urClr` is pulsed.
  - While it is set, triggers raise no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Holding-register write strobe |
| wrChan | input | 2 | Write target: 0 ch0, 1 ch1, 2 both, 3 none |
| wrFmt | input | 2 | Data layout (R2) |
| wrData | input | 32 | Write data |
| dualMode | input | 1 | Channel 1 follows channel 0 transfers |
| trigEn | input | 2 | Per-channel trigger enable |
| trigSel | input | 6 | Per-channel 3-bit trigger source select |
| extTrig | input | 7 | External trigger sources |
| swSet | input | 2 | Per-channel software trigger request pulse |
| waveMode | input | 4 | Per-channel 2-bit wave code |
| waveAmp | input | 8 | Per-channel 4-bit wave amplitude |
| dmaEn | input | 2 | Per-channel DMA request enable |
| dmaAck | input | 2 | Per-channel DMA acknowledge |
| urClr | input | 2 | Per-channel underrun clear |
| dacOut | output | 24 | Output registers, channel 0 in [11:0] |
| dmaReq | output | 2 | Per-channel DMA request |
| underrun | output | 2 | Per-channel sticky underrun flag |
| swPending | output | 2 | Per-channel software request pending |

## Verification
The bench checks the one-cycle latency of an untriggered write against the edge that loads the holding register. A design that forwards the written value directly to the output would show it a cycle early.

It fires unselected sources and holds a selected pin high. A design that decodes the select wrongly, or triggers on level instead of edge, would then transfer when it should not.

In dual mode, channel 1 has triggering disabled while its partner is triggered, which catches a design that lets channel 1's own settings leak through. The triangle runs long enough to turn at both ends, and it is driven into saturation, where a design without clipping would wrap to small values. The DMA sequence stacks three triggers without an acknowledge, so a design whose underrun flag is not sticky, or that keeps issuing requests after an underrun, is exposed.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;
  parameter int DAC_W   = 12;
  parameter int LANE_W  = 16;
  parameter int BYTE_W  = 8;
  parameter int NUM_EXT = 7;
  parameter int SEL_W   = $clog2(NUM_EXT + 1);
  parameter int AMP_W   = 4;
  parameter int NUM_CH  = 2;
  parameter int BUS_W   = NUM_CH * LANE_W;

  localparam logic [1:0] FMT_R12  = 2'd0;
  localparam logic [1:0] FMT_L12  = 2'd1;
  localparam logic [1:0] FMT_R8   = 2'd2;
  localparam logic [1:0] WR_BOTH  = 2'd2;
  localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(NUM_EXT);

  typedef enum logic [1:0] {
    WAVE_OFF   = 2'd0,
    WAVE_NOISE = 2'd1,
    WAVE_TRI   = 2'd2,
    WAVE_NONE  = 2'd3
  } wave_e;

  // strobes from a channel's control to its datapath
  typedef struct packed {
    logic direct;  // untriggered copy of held value
    logic trig;    // triggered transfer, wave added and stepped
  } xfer_t;

  function automatic logic [DAC_W-1:0] alignIn(input logic [LANE_W-1:0] lane,
                                               input logic [1:0] fmt);
    case (fmt)
      FMT_L12: return lane[LANE_W-1 -: DAC_W];
      FMT_R8:  return {lane[BYTE_W-1:0], {(DAC_W-BYTE_W){1'b0}}};
      default: return lane[DAC_W-1:0];
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] laneOf(input logic [BUS_W-1:0] data,
                                               input logic [1:0] fmt,
                                               input logic upper,
                                               input logic both);
    if (!both) return data[LANE_W-1:0];
    if (fmt == FMT_R8)
      return upper ? {{(LANE_W-BYTE_W){1'b0}}, data[2*BYTE_W-1:BYTE_W]}
                   : {{(LANE_W-BYTE_W){1'b0}}, data[BYTE_W-1:0]};
    return upper ? data[2*LANE_W-1:LANE_W] : data[LANE_W-1:0];
  endfunction

  function automatic logic [DAC_W-1:0] ampMask(input logic [AMP_W-1:0] amp);
    logic [DAC_W-1:0] m;
    for (int i = 0; i < DAC_W; i++) m[i] = (i <= int'(amp));
    return m;
  endfunction
endpackage

// File: rtl/dac_chan_ctrl.sv
module dac_chan_ctrl
  import dac_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrHit,
  input  logic               trigEn,
  input  logic [SEL_W-1:0]   trigSel,
  input  logic [NUM_EXT-1:0] extTrig,
  input  logic               swSet,
  input  logic               dmaEn,
  input  logic               dmaAck,
  input  logic               urClr,
  input  xfer_t              effXfer,
  output xfer_t              ownXfer,
  output logic               swPending,
  output logic               dmaReq,
  output logic               underrun
);
  localparam int SRC_N = 1 << SEL_W;

  logic [NUM_EXT-1:0] extPrev;
  logic               wrPend;
  logic [SRC_N-1:0]   srcVec;
  logic               swUse;
  logic               fire;

  always_comb begin
    srcVec = '0;
    srcVec[NUM_EXT-1:0] = extTrig & ~extPrev;
    srcVec[SW_CODE] = swPending;
  end

  assign swUse = trigEn && (trigSel == SW_CODE);
  assign fire  = trigEn && srcVec[trigSel];

  assign ownXfer.trig   = fire;
  assign ownXfer.direct = wrPend && !trigEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev   <= '0;
      wrPend    <= 1'b0;
      swPending <= 1'b0;
    end else begin
      extPrev <= extTrig;
      wrPend  <= wrHit;
      if (swSet)                  swPending <= 1'b1;
      else if (swUse && swPending) swPending <= 1'b0;
    end
  end

  // DMA handshake driven by the transfer this channel actually performs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReq   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (effXfer.trig && dmaEn) begin
        if (underrun) begin
          dmaReq <= 1'b0;
        end else if (dmaReq && !dmaAck) begin
          dmaReq   <= 1'b0;
          underrun <= 1'b1;
        end else begin
          dmaReq <= 1'b1;
        end
      end else if (dmaAck) begin
        dmaReq <= 1'b0;
      end
      if (urClr) underrun <= 1'b0;
    end
  end

  // R5: a consumed software request leaves nothing pending
  a_r5_sw_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    (swUse && swPending && !swSet) |=> !swPending);

  // R10: an unacknowledged request without a new transfer is held
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck && !effXfer.trig && !urClr) |=> dmaReq);

  // R11: underrun is sticky until cleared
  a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !urClr) |=> underrun);

  // R11: no request may coexist with an underrun
  a_r11_no_req_in_underrun: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !dmaReq);
endmodule

// File: rtl/dac_chan_path.sv
module dac_chan_path
  import dac_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [DAC_W-1:0] loadVal,
  input  xfer_t            xfer,
  input  logic [1:0]       waveMode,
  input  logic [AMP_W-1:0] waveAmp,
  output logic [DAC_W-1:0] dacOut
);
  localparam logic [DAC_W-1:0] LFSR_SEED = DAC_W'(12'hAAA);
  localparam logic [DAC_W-1:0] FULL      = '1;

  logic [DAC_W-1:0] hold;
  logic [DAC_W-1:0] lfsr;
  logic [DAC_W-1:0] triVal;
  logic             triDown;
  logic [DAC_W-1:0] mask;
  logic [DAC_W-1:0] waveVal;
  logic [DAC_W:0]   sum;
  logic [DAC_W-1:0] clipped;
  logic             lfsrFb;
  wave_e            mode;

  assign mode    = wave_e'(waveMode);
  assign mask    = ampMask(waveAmp);
  assign lfsrFb  = lfsr[11] ^ lfsr[5] ^ lfsr[3] ^ lfsr[0];

  always_comb begin
    case (mode)
      WAVE_NOISE: waveVal = lfsr & mask;
      WAVE_TRI:   waveVal = triVal;
      default:    waveVal = '0;
    endcase
    sum     = {1'b0, hold} + {1'b0, waveVal};
    clipped = sum[DAC_W] ? FULL : sum[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold    <= '0;
      dacOut  <= '0;
      lfsr    <= LFSR_SEED;
      triVal  <= '0;
      triDown <= 1'b0;
    end else begin
      if (loadEn) hold <= loadVal;
      if (xfer.direct) begin
        dacOut <= hold;
      end else if (xfer.trig) begin
        dacOut <= clipped;
        if (mode == WAVE_NOISE) lfsr <= {lfsr[DAC_W-2:0], lfsrFb};
        if (mode == WAVE_TRI) begin
          if (!triDown) begin
            if (triVal == mask) begin
              triDown <= 1'b1;
              triVal  <= triVal - 1'b1;
            end else begin
              triVal <= triVal + 1'b1;
            end
          end else begin
            if (triVal == '0) begin
              triDown <= 1'b0;
              triVal  <= triVal + 1'b1;
            end else begin
              triVal <= triVal - 1'b1;
            end
          end
        end
      end
    end
  end

  // R3: an untriggered transfer copies the held value unchanged
  a_r3_direct_copy: assert property (@(posedge clk) disable iff (!rstN)
    xfer.direct |=> dacOut == $past(hold));

  // R9: a triggered result never falls below the held value
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (xfer.trig && !xfer.direct) |=> dacOut >= $past(hold));

  // R8: with wave off a triggered transfer adds nothing
  a_r8_off_adds_zero: assert property (@(posedge clk) disable iff (!rstN)
    (xfer.trig && !xfer.direct && (waveMode == 2'd0)) |=> dacOut == $past(hold));
endmodule

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
  import dac_pair_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [1:0]                wrChan,
  input  logic [1:0]                wrFmt,
  input  logic [BUS_W-1:0]          wrData,
  input  logic                      dualMode,
  input  logic [NUM_CH-1:0]         trigEn,
  input  logic [NUM_CH*SEL_W-1:0]   trigSel,
  input  logic [NUM_EXT-1:0]        extTrig,
  input  logic [NUM_CH-1:0]         swSet,
  input  logic [NUM_CH*2-1:0]       waveMode,
  input  logic [NUM_CH*AMP_W-1:0]   waveAmp,
  input  logic [NUM_CH-1:0]         dmaEn,
  input  logic [NUM_CH-1:0]         dmaAck,
  input  logic [NUM_CH-1:0]         urClr,
  output logic [NUM_CH*DAC_W-1:0]   dacOut,
  output logic [NUM_CH-1:0]         dmaReq,
  output logic [NUM_CH-1:0]         underrun,
  output logic [NUM_CH-1:0]         swPending
);
  xfer_t ownX [NUM_CH];
  xfer_t effX [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic              wrHit;
    logic [LANE_W-1:0] lane;

    assign wrHit = wrEn && ((wrChan == 2'(g)) || (wrChan == WR_BOTH));
    assign lane  = laneOf(wrData, wrFmt, (g != 0), (wrChan == WR_BOTH));

    if (g == 0) begin : gLead
      assign effX[g] = ownX[g];
    end else begin : gFollow
      assign effX[g] = dualMode ? ownX[0] : ownX[g];
    end

    dac_chan_ctrl uCtrl (
      .clk       (clk),
      .rstN      (rstN),
      .wrHit     (wrHit),
      .trigEn    (trigEn[g]),
      .trigSel   (trigSel[g*SEL_W +: SEL_W]),
      .extTrig   (extTrig),
      .swSet     (swSet[g]),
      .dmaEn     (dmaEn[g]),
      .dmaAck    (dmaAck[g]),
      .urClr     (urClr[g]),
      .effXfer   (effX[g]),
      .ownXfer   (ownX[g]),
      .swPending (swPending[g]),
      .dmaReq    (dmaReq[g]),
      .underrun  (underrun[g])
    );

    dac_chan_path uPath (
      .clk      (clk),
      .rstN     (rstN),
      .loadEn   (wrHit),
      .loadVal  (alignIn(lane, wrFmt)),
      .xfer     (effX[g]),
      .waveMode (waveMode[g*2 +: 2]),
      .waveAmp  (waveAmp[g*AMP_W +: AMP_W]),
      .dacOut   (dacOut[g*DAC_W +: DAC_W])
    );
  end

  // R6: in dual mode both channels move on the same edge
  a_r6_dual_lockstep: assert property (@(posedge clk) disable iff (!rstN)
    dualMode |-> (effX[1] == effX[0]));
endmodule

// File: tb/dac_pair_ctrl_test.sv
module dac_pair_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrChan = '0;
  logic [1:0]  wrFmt = '0;
  logic [31:0] wrData = '0;
  logic        dualMode = 1'b0;
  logic [1:0]  trigEn = '0;
  logic [5:0]  trigSel = '0;
  logic [6:0]  extTrig = '0;
  logic [1:0]  swSet = '0;
  logic [3:0]  waveMode = '0;
  logic [7:0]  waveAmp = '0;
  logic [1:0]  dmaEn = '0;
  logic [1:0]  dmaAck = '0;
  logic [1:0]  urClr = '0;
  logic [23:0] dacOut;
  logic [1:0]  dmaReq;
  logic [1:0]  underrun;
  logic [1:0]  swPending;

  int checks = 0;
  int failures = 0;
  logic [11:0] lfsrM = 12'hAAA;
  int triV = 0;
  bit triD = 0;

  always #5 clk = ~clk;

  dac_pair_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrFmt(wrFmt),
    .wrData(wrData), .dualMode(dualMode), .trigEn(trigEn), .trigSel(trigSel),
    .extTrig(extTrig), .swSet(swSet), .waveMode(waveMode), .waveAmp(waveAmp),
    .dmaEn(dmaEn), .dmaAck(dmaAck), .urClr(urClr), .dacOut(dacOut),
    .dmaReq(dmaReq), .underrun(underrun), .swPending(swPending)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] out(input int c);
    return dacOut[c*12 +: 12];
  endfunction

  task automatic wr(input logic [1:0] ch, input logic [1:0] fmt, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrChan = ch; wrFmt = fmt; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic swFire(input int c);
    @(negedge clk); swSet[c] = 1;
    @(negedge clk); swSet[c] = 0;
    @(negedge clk);
  endtask

  task automatic extFire(input int i);
    @(negedge clk); extTrig[i] = 1;
    @(negedge clk); extTrig[i] = 0;
  endtask

  task automatic testReset();
    chk("R1", "out0", out(0), 0);
    chk("R1", "out1", out(1), 0);
    chk("R1", "dmaReq", dmaReq, 0);
    chk("R1", "underrun", underrun, 0);
    chk("R1", "swPending", swPending, 0);
  endtask

  task automatic testFormats();
    trigEn = 2'b00;
    wr(0, 0, 32'h0000_0ABC);
    chk("R3", "out0 before latency", out(0), 0);
    @(negedge clk);
    chk("R2", "right12", out(0), 12'hABC);
    wr(0, 1, 32'h0000_1230);
    @(negedge clk);
    chk("R2", "left12", out(0), 12'h123);
    wr(0, 2, 32'h0000_005C);
    @(negedge clk);
    chk("R2", "byte", out(0), 12'h5C0);
    wr(1, 0, 32'h0000_0321);
    @(negedge clk);
    chk("R2", "ch1 right12", out(1), 12'h321);
    chk("R2", "ch0 untouched", out(0), 12'h5C0);
    extFire(0);
    @(negedge clk);
    chk("R3", "ext ignored when untriggered", out(0), 12'h5C0);
  endtask

  task automatic testTrigSel();
    trigSel[2:0] = 3'd3; trigEn[0] = 1;
    wr(0, 0, 32'h0000_0456);
    repeat (2) @(negedge clk);
    chk("R4", "no trigger no change", out(0), 12'h5C0);
    extFire(5);
    @(negedge clk);
    chk("R4", "unselected source", out(0), 12'h5C0);
    @(negedge clk); extTrig[3] = 1;
    @(negedge clk);
    chk("R4", "selected edge", out(0), 12'h456);
    wr(0, 0, 32'h0000_0457);
    repeat (2) @(negedge clk);
    chk("R4", "held level no retrigger", out(0), 12'h456);
    extTrig[3] = 0;
  endtask

  task automatic testSwTrig();
    trigSel[2:0] = 3'd7;
    wr(0, 0, 32'h0000_0789);
    @(negedge clk); swSet[0] = 1;
    @(negedge clk); swSet[0] = 0;
    chk("R5", "pending set", swPending[0], 1);
    chk("R5", "not yet moved", out(0), 12'h456);
    @(negedge clk);
    chk("R5", "sw transfer", out(0), 12'h789);
    chk("R5", "pending cleared", swPending[0], 0);
  endtask

  task automatic testDual();
    dualMode = 1; trigSel[2:0] = 3'd2; trigEn = 2'b01;
    wr(2, 2, 32'h0000_B7A5);
    @(negedge clk);
    chk("R6", "ch0 waits", out(0), 12'h789);
    chk("R6", "ch1 waits", out(1), 12'h321);
    extFire(2);
    chk("R6", "ch0 updated", out(0), 12'hA50);
    chk("R6", "ch1 updated", out(1), 12'hB70);
    dualMode = 0;
    wr(2, 0, 32'h0654_0123);
    @(negedge clk);
    chk("R2", "dual lane ch1 direct", out(1), 12'h654);
    chk("R6", "ch0 still waits", out(0), 12'hA50);
  endtask

  task automatic testNoise();
    logic [11:0] exp;
    trigSel[2:0] = 3'd7; waveMode[1:0] = 2'd1; waveAmp[3:0] = 4'd3;
    wr(0, 0, 32'h0000_0100);
    for (int k = 0; k < 5; k++) begin
      exp = 12'h100 + (lfsrM & 12'h00F);
      swFire(0);
      chk("R7", "noise sample", out(0), exp);
      lfsrM = {lfsrM[10:0], lfsrM[11] ^ lfsrM[5] ^ lfsrM[3] ^ lfsrM[0]};
    end
    waveMode[1:0] = 2'd0;
  endtask

  task automatic triStep(input int mx);
    if (!triD) begin
      if (triV == mx) begin triD = 1; triV--; end else triV++;
    end else begin
      if (triV == 0) begin triD = 0; triV++; end else triV--;
    end
  endtask

  task automatic testTriangle();
    trigEn[1] = 1; trigSel[5:3] = 3'd7; waveMode[3:2] = 2'd2; waveAmp[7:4] = 4'd1;
    wr(1, 0, 32'h0000_0200);
    for (int k = 0; k < 8; k++) begin
      swFire(1);
      chk("R8", "triangle sample", out(1), 12'h200 + triV);
      triStep(3);
    end
  endtask

  task automatic testClip();
    int s;
    waveAmp[7:4] = 4'd7;
    wr(1, 0, 32'h0000_0FF0);
    for (int k = 0; k < 20; k++) begin
      s = 12'hFF0 + triV;
      if (s > 12'hFFF) s = 12'hFFF;
      swFire(1);
      chk("R9", "saturated sum", out(1), s);
      triStep(255);
    end
  endtask

  task automatic testDma();
    dmaEn[0] = 1; trigSel[2:0] = 3'd7; trigEn[0] = 1;
    swFire(0);
    chk("R10", "request raised", dmaReq[0], 1);
    repeat (2) @(negedge clk);
    chk("R10", "request held", dmaReq[0], 1);
    dmaAck[0] = 1; @(negedge clk); dmaAck[0] = 0;
    chk("R10", "request acked", dmaReq[0], 0);
    swFire(0);
    chk("R10", "second request", dmaReq[0], 1);
    swFire(0);
    chk("R11", "underrun set", underrun[0], 1);
    chk("R11", "request dropped", dmaReq[0], 0);
    swFire(0);
    chk("R11", "no request in underrun", dmaReq[0], 0);
    chk("R11", "underrun sticky", underrun[0], 1);
    urClr[0] = 1; @(negedge clk); urClr[0] = 0;
    chk("R11", "underrun cleared", underrun[0], 0);
    swFire(0);
    chk("R10", "request after clear", dmaReq[0], 1);
    chk("R11", "no new underrun", underrun[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testFormats();
    testTrigSel();
    testSwTrig();
    testDual();
    testNoise();
    testTriangle();
    testClip();
    testDma();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule